// File: doc/BRIEF.md
# TDM Audio Frame Clock Generator

This block derives the bit clock and frame clock of a multichannel serial audio port from the master audio clock. It runs on a core clock that is a fixed integer multiple of the master clock (parameter `CORE_PER_MCLK`, default 2). It counts core cycles into bit periods and bit periods into frames. It produces both audio clocks as registered outputs, together with output-enable flags for the pads.

A mode input chooses between two roles. In master operation the block drives both audio clocks. In slave operation it releases them and instead watches an external frame clock, raising a one-cycle frame-start flag on each frame edge.

A format input selects either two-slot I2S framing or a TDM frame. The TDM frame has 4, 8 or 16 slots and uses either a one-bit-period pulse or a square-wave frame clock. A ratio input states whether the master clock is 256 or 384 times the sample rate. Any combination whose bit-clock divide is fractional, or too fast for a register-built clock, is flagged and produces no clocks.

Top module: `tdm_clkgen`

## Requirements
- R1: While rst_ni is low, every output is 0, and the active setting is master, ratio 256, I2S.
- R2: `bclk_oe_o` and `fclk_oe_o` are 1 exactly when the active setting is master (`slave_i`=0) and supported. When they are 0, `bclk_o` and `fclk_o` stay 0.
- R3: The bit period is D core cycles, where D = CORE_PER_MCLK × R / B. R is 256 when `ratio_hi_i`=0 and 384 when it is 1. B is the frame length in bit periods. `bclk_o` is low for the first floor(D/2) core cycles of each bit period and high for the rest.
- R4: With `tdm_i`=0 (I2S), a frame is 64 bit periods. `fclk_o` is low for bits 0 to 31 and high for bits 32 to 63, so it changes one bit period before each channel's first data bit.
- R5: With `tdm_i`=1, `tdm_sel_i`=00, 01 and 10 select frames of 4, 8 and 16 slots of 32 bits each. In these frames `fclk_o` is high only during bit 0.
- R6: With `tdm_i`=1 and `tdm_sel_i`=11, the frame has 8 slots of 32 bits, and `fclk_o` is high for bits 0 to 127 and low for bits 128 to 255.
- R7: A master setting whose D is not an integer, or is below 2, sets `unsupported_o`=1 and drives no clocks. While such a setting is active, any new input setting is taken on the next core edge.
- R8: A new input setting becomes active only at a frame boundary. In master operation the boundary is the last core cycle of the frame. In slave operation it is a detected external frame start. The bit and core counters restart from zero when the setting is loaded.
- R9: In master operation, `frame_start_o` is 1 for exactly one core cycle, during the first core cycle of bit 0 of each frame.
- R10: In slave operation, `ext_fclk_i` passes through a two-stage synchronizer. A rising edge (TDM) or falling edge (I2S) first sampled at core edge k makes `frame_start_o` 1 for the one cycle after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, CORE_PER_MCLK times the master audio clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_i | input | 1 | 0 = master (drive clocks), 1 = slave |
| ratio_hi_i | input | 1 | 0 = master clock 256 × fS, 1 = 384 × fS |
| tdm_i | input | 1 | 0 = I2S framing, 1 = TDM framing |
| tdm_sel_i | input | 2 | TDM frame select: 00 TDM4, 01 TDM8, 10 TDM16 (pulse), 11 TDM8 square |
| ext_fclk_i | input | 1 | External frame clock, used in slave operation |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Generated frame clock |
| bclk_oe_o | output | 1 | Bit clock pad drive enable |
| fclk_oe_o | output | 1 | Frame clock pad drive enable |
| frame_start_o | output | 1 | One-cycle frame start flag |
| unsupported_o | output | 1 | Active master setting cannot be generated |

## Verification
Every clock output is registered from the next counter state. Each result is therefore due on the core edge that moves the counters, and the bench's reference model advances on that same edge. The outputs are compared half a cycle later, on the falling edge.

A setting change is due at the frame end the model predicts. That can be hundreds of cycles after the inputs move, so the same per-cycle comparison covers the delay.

The slave frame-start flag is due two edges after the external edge is first sampled. The model keeps its own three-deep history of `ext_fclk_i` to place that pulse.

// File: rtl/tdm_clkgen_pkg.sv
package tdm_clkgen_pkg;
  typedef struct packed {
    logic       slave;
    logic       ratio_hi;
    logic       tdm;
    logic [1:0] sel;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RST = '0;
endpackage

// File: rtl/tdm_clkgen_div.sv
module tdm_clkgen_div
  import tdm_clkgen_pkg::*;
#(
  parameter int CORE_PER_MCLK = 2,
  parameter int RATIO_LO      = 256,
  parameter int RATIO_HI      = 384,
  parameter int SLOT_BITS     = 32,
  parameter int DW            = 4,
  parameter int FW            = 10
) (
  input  clk_cfg_t        cfg_i,
  output logic [DW-1:0]   div_o,
  output logic [FW-1:0]   fbits_o,
  output logic            ok_o
);
  localparam int N_KIND = 4;  // frame kinds: 2, 4, 8, 16 slots

  logic [DW-1:0] div_tab   [2*N_KIND];
  logic          ok_tab    [2*N_KIND];
  logic [FW-1:0] fbits_tab [N_KIND];

  for (genvar r = 0; r < 2; r++) begin : g_ratio
    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
      localparam int NUM = CORE_PER_MCLK * ((r == 1) ? RATIO_HI : RATIO_LO);
      localparam int FB  = SLOT_BITS * (2 << k);
      localparam bit OK  = ((NUM % FB) == 0) && ((NUM / FB) >= 2);
      assign div_tab[r*N_KIND+k] = OK ? DW'(NUM / FB) : '0;
      assign ok_tab[r*N_KIND+k]  = OK;
    end
  end

  for (genvar k = 0; k < N_KIND; k++) begin : g_fbits
    assign fbits_tab[k] = FW'(SLOT_BITS * (2 << k));
  end

  logic [1:0] kind;
  always_comb begin
    if (!cfg_i.tdm)            kind = 2'd0;
    else if (cfg_i.sel == 2'b11) kind = 2'd2;
    else                       kind = cfg_i.sel + 2'd1;
  end

  assign div_o   = div_tab[{cfg_i.ratio_hi, kind}];
  assign ok_o    = ok_tab[{cfg_i.ratio_hi, kind}];
  assign fbits_o = fbits_tab[kind];
endmodule

// File: rtl/tdm_clkgen_timer.sv
module tdm_clkgen_timer #(
  parameter int DW = 4,
  parameter int FW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [DW-1:0] div_i,
  input  logic [FW-1:0] fbits_i,
  output logic [DW-1:0] mcnt_o,
  output logic [FW-1:0] bcnt_o,
  output logic [DW-1:0] mcnt_d_o,
  output logic [FW-1:0] bcnt_d_o,
  output logic          frame_end_o
);
  logic [DW-1:0] mcnt_q, mcnt_d;
  logic [FW-1:0] bcnt_q, bcnt_d;
  logic          mcnt_last, bcnt_last;

  assign mcnt_last = (mcnt_q == div_i - DW'(1));
  assign bcnt_last = (bcnt_q == fbits_i - FW'(1));

  always_comb begin
    mcnt_d = mcnt_q;
    bcnt_d = bcnt_q;
    if (load_i || !run_i) begin
      mcnt_d = '0;
      bcnt_d = '0;
    end else if (mcnt_last) begin
      mcnt_d = '0;
      bcnt_d = bcnt_last ? '0 : bcnt_q + FW'(1);
    end else begin
      mcnt_d = mcnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      mcnt_q <= mcnt_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign mcnt_o      = mcnt_q;
  assign bcnt_o      = bcnt_q;
  assign mcnt_d_o    = mcnt_d;
  assign bcnt_d_o    = bcnt_d;
  assign frame_end_o = run_i && mcnt_last && bcnt_last;
endmodule

// File: rtl/tdm_clkgen_edge.sv
module tdm_clkgen_edge #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], d_i};
  end

  assign rise_o =  sh_q[SYNC-1] & ~sh_q[SYNC];
  assign fall_o = ~sh_q[SYNC-1] &  sh_q[SYNC];
endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
  import tdm_clkgen_pkg::*;
#(
  parameter int CORE_PER_MCLK = 2,
  parameter int RATIO_LO      = 256,
  parameter int RATIO_HI      = 384,
  parameter int SLOT_BITS     = 32,
  parameter int SYNC          = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slave_i,
  input  logic       ratio_hi_i,
  input  logic       tdm_i,
  input  logic [1:0] tdm_sel_i,
  input  logic       ext_fclk_i,
  output logic       bclk_o,
  output logic       fclk_o,
  output logic       bclk_oe_o,
  output logic       fclk_oe_o,
  output logic       frame_start_o,
  output logic       unsupported_o
);
  localparam int MAX_DIV = CORE_PER_MCLK * RATIO_HI / (2 * SLOT_BITS);
  localparam int DW      = $clog2(MAX_DIV + 1);
  localparam int FW      = $clog2(SLOT_BITS * 16 + 1);

  clk_cfg_t      act_q, act_d, cfg_in;
  logic [DW-1:0] div_c, div_n, mcnt_q, mcnt_d;
  logic [FW-1:0] fbits_c, fbits_n, bcnt_q, bcnt_d;
  logic          ok_c, ok_n, run, run_n, load, frame_end;
  logic          ext_rise, ext_fall, slave_start;
  logic          bclk_q, fclk_q, oe_q, fs_q, unsup_q;
  logic          bclk_d, fclk_d, fs_d;

  assign cfg_in = '{slave: slave_i, ratio_hi: ratio_hi_i, tdm: tdm_i, sel: tdm_sel_i};

  // divide for the setting in force and for the one about to be
  tdm_clkgen_div #(
    .CORE_PER_MCLK(CORE_PER_MCLK), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI),
    .SLOT_BITS(SLOT_BITS), .DW(DW), .FW(FW)
  ) u_div_cur (.cfg_i(act_q), .div_o(div_c), .fbits_o(fbits_c), .ok_o(ok_c));

  tdm_clkgen_div #(
    .CORE_PER_MCLK(CORE_PER_MCLK), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI),
    .SLOT_BITS(SLOT_BITS), .DW(DW), .FW(FW)
  ) u_div_nxt (.cfg_i(act_d), .div_o(div_n), .fbits_o(fbits_n), .ok_o(ok_n));

  tdm_clkgen_edge #(.SYNC(SYNC)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_fclk_i),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  assign run         = !act_q.slave && ok_c;
  assign slave_start = act_q.slave && (act_q.tdm ? ext_rise : ext_fall);

  always_comb begin
    if (act_q.slave) load = slave_start;
    else if (!ok_c)  load = 1'b1;
    else             load = frame_end;
  end

  assign act_d = load ? cfg_in : act_q;
  assign run_n = !act_d.slave && ok_n;

  tdm_clkgen_timer #(.DW(DW), .FW(FW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .load_i(load),
    .div_i(div_c), .fbits_i(fbits_c),
    .mcnt_o(mcnt_q), .bcnt_o(bcnt_q), .mcnt_d_o(mcnt_d), .bcnt_d_o(bcnt_d),
    .frame_end_o(frame_end)
  );

  // outputs registered from next counter state
  always_comb begin
    bclk_d = run_n && (mcnt_d >= (div_n >> 1));
    if (!run_n)                     fclk_d = 1'b0;
    else if (!act_d.tdm)            fclk_d = (bcnt_d >= FW'(SLOT_BITS));
    else if (act_d.sel == 2'b11)    fclk_d = (bcnt_d < (fbits_n >> 1));
    else                            fclk_d = (bcnt_d == '0);
    fs_d = act_q.slave ? slave_start
                       : (run_n && (mcnt_d == '0) && (bcnt_d == '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= CFG_RST;
      bclk_q  <= 1'b0;
      fclk_q  <= 1'b0;
      oe_q    <= 1'b0;
      fs_q    <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      bclk_q  <= bclk_d;
      fclk_q  <= fclk_d;
      oe_q    <= run_n;
      fs_q    <= fs_d;
      unsup_q <= !act_d.slave && !ok_n;
    end
  end

  assign bclk_o        = bclk_q;
  assign fclk_o        = fclk_q;
  assign bclk_oe_o     = oe_q;
  assign fclk_oe_o     = oe_q;
  assign frame_start_o = fs_q;
  assign unsupported_o = unsup_q;
endmodule

// File: rtl/tdm_clkgen_chk.sv
module tdm_clkgen_chk
  import tdm_clkgen_pkg::*;
#(
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bclk_o,
  input logic          fclk_o,
  input logic          bclk_oe_o,
  input logic          frame_start_o,
  input logic          unsupported_o,
  input clk_cfg_t      act_q,
  input logic          load,
  input logic          run,
  input logic [DW-1:0] mcnt_q,
  input logic [DW-1:0] div_c
);
  assert_clk_needs_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_o || fclk_o) |-> bclk_oe_o);

  assert_unsup_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |-> (!bclk_o && !fclk_o && !bclk_oe_o));

  assert_mcnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (mcnt_q < div_c));

  assert_cfg_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(load));

  assert_fs_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && !act_q.slave) |=> !frame_start_o);

  assert_tdm_fs_fclk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && bclk_oe_o && act_q.tdm) |-> fclk_o);

  assert_i2s_fs_left_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && bclk_oe_o && !act_q.tdm) |-> !fclk_o);
endmodule

bind tdm_clkgen tdm_clkgen_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bclk_o(bclk_o), .fclk_o(fclk_o),
  .bclk_oe_o(bclk_oe_o), .frame_start_o(frame_start_o),
  .unsupported_o(unsupported_o), .act_q(act_q), .load(load), .run(run),
  .mcnt_q(mcnt_q), .div_c(div_c)
);

// File: tb/tdm_clkgen_bench.sv
`timescale 1ns/1ps
module tdm_clkgen_bench;
  localparam int OVS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slave = 1'b0, ratio_hi = 1'b0, tdm = 1'b0, ext_fclk = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       bclk, fclk, bclk_oe, fclk_oe, fs, unsup;

  int  n_checks = 0, n_errors = 0, cyc = 0;
  bit  started = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  tdm_clkgen u_tdm_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .slave_i(slave), .ratio_hi_i(ratio_hi),
    .tdm_i(tdm), .tdm_sel_i(sel), .ext_fclk_i(ext_fclk),
    .bclk_o(bclk), .fclk_o(fclk), .bclk_oe_o(bclk_oe), .fclk_oe_o(fclk_oe),
    .frame_start_o(fs), .unsupported_o(unsup)
  );

  function automatic int f_fb(input bit t, input int s);
    if (!t) return 64;
    case (s)
      0: return 128;
      1: return 256;
      2: return 512;
      default: return 256;
    endcase
  endfunction

  function automatic int f_div(input bit r, input bit t, input int s);
    int num = OVS * (r ? 384 : 256);
    int fb  = f_fb(t, s);
    if ((num % fb) != 0 || (num / fb) < 2) return 0;
    return num / fb;
  endfunction

  // reference model state
  bit m_slave, m_ratio, m_tdm;
  int m_sel, mc, bc;
  bit s1, s2, s3;
  bit e_bclk, e_fclk, e_oe, e_fs, e_unsup;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slave = 0; m_ratio = 0; m_tdm = 0; m_sel = 0; mc = 0; bc = 0;
      s1 = 0; s2 = 0; s3 = 0;
      e_bclk = 0; e_fclk = 0; e_oe = 0; e_fs = 0; e_unsup = 0;
    end else begin
      int d, fb, nd, nfb;
      bit run, sst, load, was_slave, nrun;
      d   = f_div(m_ratio, m_tdm, m_sel);
      fb  = f_fb(m_tdm, m_sel);
      run = !m_slave && d != 0;
      sst = m_slave && (m_tdm ? (s2 && !s3) : (!s2 && s3));
      if (m_slave) load = sst;
      else if (d == 0) load = 1;
      else load = (mc == d-1) && (bc == fb-1);
      was_slave = m_slave;
      if (load) begin
        m_slave = slave; m_ratio = ratio_hi; m_tdm = tdm; m_sel = int'(sel);
        mc = 0; bc = 0;
      end else if (run) begin
        if (mc == d-1) begin
          mc = 0;
          bc = (bc == fb-1) ? 0 : bc + 1;
        end else mc++;
      end else begin
        mc = 0; bc = 0;
      end
      s3 = s2; s2 = s1; s1 = ext_fclk;
      nd   = f_div(m_ratio, m_tdm, m_sel);
      nfb  = f_fb(m_tdm, m_sel);
      nrun = !m_slave && nd != 0;
      e_bclk  = nrun && (mc >= nd/2);
      if (!nrun)          e_fclk = 0;
      else if (!m_tdm)    e_fclk = (bc >= 32);
      else if (m_sel == 3) e_fclk = (bc < nfb/2);
      else                e_fclk = (bc == 0);
      e_fs    = was_slave ? sst : (nrun && mc == 0 && bc == 0);
      e_oe    = nrun;
      e_unsup = !m_slave && nd == 0;
      started = 1'b1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s [%s] cycle %0d: actual=%b expected=%b", req, phase, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk("R1 bclk", bclk, 1'b0);
      chk("R1 fclk", fclk, 1'b0);
      chk("R1 oe", bclk_oe, 1'b0);
      chk("R1 fs", fs, 1'b0);
      chk("R1 unsup", unsup, 1'b0);
    end else if (started) begin
      chk("R3 bclk", bclk, e_bclk);
      chk(m_tdm ? ((m_sel == 3) ? "R6 fclk" : "R5 fclk") : "R4 fclk", fclk, e_fclk);
      chk("R2 bclk_oe", bclk_oe, e_oe);
      chk("R2 fclk_oe", fclk_oe, e_oe);
      chk(m_slave ? "R10 frame_start" : "R9 frame_start", fs, e_fs);
      chk("R7 unsupported", unsup, e_unsup);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ext_fclk = 1'b1; wait_cyc(hi);
      ext_fclk = 1'b0; wait_cyc(lo);
    end
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    phase = "R4 default I2S 256";
    wait_cyc(600);
    phase = "R8 ratio change mid-frame, R3";
    ratio_hi = 1'b1;
    wait_cyc(1600);
    phase = "R5 TDM4 384";
    tdm = 1'b1; sel = 2'b00;
    wait_cyc(1600);
    phase = "R5 TDM8 256";
    ratio_hi = 1'b0; sel = 2'b01;
    wait_cyc(1300);
    phase = "R6 TDM8 square 384";
    ratio_hi = 1'b1; sel = 2'b11;
    wait_cyc(1700);
    phase = "R7 TDM16 unsupported";
    sel = 2'b10;
    wait_cyc(900);
    phase = "R7 immediate reload to TDM4 256";
    ratio_hi = 1'b0; sel = 2'b00;
    wait_cyc(600);
    phase = "R10 slave TDM rising edges";
    slave = 1'b1;
    wait_cyc(600);
    ext_pulses(4, 3, 20);
    phase = "R8 slave to master I2S on external edge";
    slave = 1'b0; tdm = 1'b0;
    wait_cyc(10);
    ext_pulses(1, 3, 20);
    wait_cyc(1200);
    phase = "R10 slave I2S falling edges";
    slave = 1'b1;
    wait_cyc(600);
    ext_pulses(4, 15, 15);
    wait_cyc(20);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule